// File: doc/BRIEF.md
# EDO DRAM Output Path Controller

This block models, at clock-cycle level, the data output side of an extended-data-out DRAM with a 16-bit data bus. The row strobe, column strobe, write enable and output enable are active low and are sampled on a fast internal clock, and the block finds their edges from those samples. From these edges it decides three things: when the internal I/O path opens, when the output latch takes new data, and when the tri-state drivers are on. A small behavioural cell array supplies the read data and takes the written data.

Both the row and the column address arrive on one multiplexed address bus. The row is taken when the row strobe falls and the column when the column strobe falls. The block supports these cycle types:

- read, early write, late write and read-modify-write
- page cycles within one open row
- RAS-only refresh
- CAS-before-RAS refresh, including hidden refresh
- CAS-only cycles

In place of a bidirectional pin, the block brings out a data output bus, a separate driver-enable signal and a data input bus.

Top module: `edo_out_ctrl`

## Requirements
- R1: After reset the driver enable `dq_oe` is 0.
- R2: When the row is open and the column strobe falls with `we_n` high, the cell {row, column} goes into the output latch. From the next clock on, `dq_oe` is 1 if `oe_n` is low and `dq_out` shows that cell.
- R3: In page mode, a rising column strobe leaves the drivers on and leaves `dq_out` unchanged. The next column strobe fall in the same row drives the new column.
- R4: When the row strobe rises while the column strobe is still low, the latched data stays driven. The drivers turn off at the first sampled clock where both strobes are high.
- R5: `oe_n` high forces `dq_oe` to 0 in the same cycle and leaves `dq_out` unchanged. `oe_n` low again restores driving.
- R6: In an early write (`we_n` low at the column strobe fall), `dq_in` is written to the addressed cell and `dq_oe` stays 0.
- R7: In a late write or read-modify-write cycle, `we_n` falls while the column strobe is low. That writes `dq_in` to the column captured at the column strobe fall and turns the drivers off. Before that, the drivers follow `oe_n`.
- R8: A row strobe fall with the column strobe high and no column strobe fall (RAS-only refresh) keeps `dq_oe` at 0. It changes no cell, even if `we_n` falls.
- R9: A row strobe fall with the column strobe already low starts a CAS-before-RAS refresh. That cycle makes no array access, and the driver state and `dq_out` stay as they were.
- R10: A column strobe fall while the row strobe is high changes neither the drivers nor any cell.
- R11: The row index is taken from `addr` at the row strobe fall, and the cell index is {row, column}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DW | Write data |
| dq_out | output | DW | Output latch contents |
| dq_oe | output | 1 | Tri-state driver enable |

## Verification
The bench builds the block with its defaults: 16-bit data and three row and three column address bits. With these values the whole 64-cell array fits into a short run. Every cell is written by early-write page cycles with a pattern computed from its row and column. Every cell is then read back in page mode, checking both the falling and the rising column strobe, which covers the address mapping and the EDO hold on every cell. The remaining cycle types are run on chosen cells, and a final sweep over all cells shows that refresh and CAS-only cycles changed nothing.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef struct packed {
    logic ras_fall;
    logic ras_rise;
    logic cas_fall;
    logic cas_rise;
    logic we_fall;
  } strobe_ev_t;
endpackage

// File: rtl/edo_strobe_edges.sv
module edo_strobe_edges
  import edo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  output strobe_ev_t ev
);
  logic ras_q, cas_q, we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      we_q  <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
    end
  end

  always_comb begin
    ev.ras_fall = ras_q & ~ras_n;
    ev.ras_rise = ~ras_q & ras_n;
    ev.cas_fall = cas_q & ~cas_n;
    ev.cas_rise = ~cas_q & cas_n;
    ev.we_fall  = we_q & ~we_n;
  end
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
  parameter int DW = 16,
  parameter int IW = 6,
  localparam int DEPTH = 1 << IW
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_data;
  end

  assign rd_data = cells[rd_idx];
endmodule

// File: rtl/edo_out_latch.sv
module edo_out_latch #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          kill,
  output logic          drv,
  output logic [DW-1:0] dat
);
  logic          drv_nxt;
  logic [DW-1:0] dat_nxt;

  always_comb begin
    drv_nxt = drv;
    dat_nxt = dat;
    if (load) begin
      drv_nxt = 1'b1;
      dat_nxt = load_data;
    end else if (kill) begin
      drv_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv <= 1'b0;
      dat <= '0;
    end else begin
      drv <= drv_nxt;
      if (load) dat <= dat_nxt;
    end
  end
endmodule

// File: rtl/edo_out_ctrl.sv
module edo_out_ctrl
  import edo_pkg::*;
#(
  parameter int DW     = 16,
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     dq_in,
  output logic [DW-1:0]     dq_out,
  output logic              dq_oe
);
  localparam int IW = ROW_W + COL_W;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  strobe_ev_t ev;
  edo_strobe_edges u_edges (
    .clk(clk), .rst_n(rst_int_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ev(ev)
  );

  logic             row_act, row_act_nxt;
  logic             cbr, cbr_nxt;
  logic             io_open, io_open_nxt;
  logic [ROW_W-1:0] row_q, row_nxt;
  logic [COL_W-1:0] col_q, col_nxt;
  logic             access_ok, cas_go, early_wr, late_wr;
  logic             load, kill, drv;
  logic [IW-1:0]    rd_idx, wr_idx;
  logic [DW-1:0]    rd_data;

  always_comb begin
    access_ok = row_act & ~cbr & ~ras_n;
    cas_go    = access_ok & ev.cas_fall;
    early_wr  = cas_go & ~we_n;
    late_wr   = access_ok & io_open & ev.we_fall & ~cas_n;
    load      = cas_go & we_n;
    kill      = (ras_n & cas_n) | (ev.ras_fall & cas_n) | early_wr
              | (access_ok & io_open & ~cas_n & ~we_n);
    rd_idx    = {row_q, addr[COL_W-1:0]};
    wr_idx    = early_wr ? {row_q, addr[COL_W-1:0]} : {row_q, col_q};
  end

  always_comb begin
    row_act_nxt = row_act;
    cbr_nxt     = cbr;
    io_open_nxt = io_open;
    row_nxt     = row_q;
    col_nxt     = col_q;
    if (ev.ras_fall) begin
      row_act_nxt = 1'b1;
      cbr_nxt     = ~cas_n;
      if (cas_n) row_nxt = addr[ROW_W-1:0];
    end
    if (ev.ras_rise) begin
      row_act_nxt = 1'b0;
      cbr_nxt     = 1'b0;
      io_open_nxt = 1'b0;
    end
    if (cas_go) begin
      col_nxt     = addr[COL_W-1:0];
      io_open_nxt = 1'b1;
    end
    if (ev.cas_rise) io_open_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      row_act <= 1'b0;
      cbr     <= 1'b0;
      io_open <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      row_act <= row_act_nxt;
      cbr     <= cbr_nxt;
      io_open <= io_open_nxt;
      if (ev.ras_fall) row_q <= row_nxt;
      if (cas_go)      col_q <= col_nxt;
    end
  end

  edo_cell_array #(.DW(DW), .IW(IW)) u_array (
    .clk(clk), .wr_en(early_wr | late_wr), .wr_idx(wr_idx), .wr_data(dq_in),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  edo_out_latch #(.DW(DW)) u_latch (
    .clk(clk), .rst_n(rst_int_n), .load(load), .load_data(rd_data),
    .kill(kill), .drv(drv), .dat(dq_out)
  );

  assign dq_oe = drv & ~oe_n;
endmodule

// File: rtl/edo_out_ctrl_chk.sv
module edo_out_ctrl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          dq_oe,
  input logic [DW-1:0] dq_out,
  input logic          row_act,
  input logic          cbr,
  input logic          io_open,
  input logic          drv
);
  // R5
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);
  // R4
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && cas_n) |=> !dq_oe);
  // R8
  ras_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && cas_n) |=> !dq_oe);
  // R9
  cbr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |=> ($stable(drv) && $stable(dq_out)));
  // R6
  early_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_act && !cbr && !ras_n && $fell(cas_n) && !we_n) |=> !dq_oe);
  // R7
  late_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_open && !ras_n && !cas_n && !we_n) |=> !dq_oe);
  // R10
  cas_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && !cas_n && $past(ras_n && cas_n)) |=> !dq_oe);
endmodule

bind edo_out_ctrl edo_out_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .oe_n(oe_n), .dq_oe(dq_oe), .dq_out(dq_out), .row_act(row_act), .cbr(cbr),
  .io_open(io_open), .drv(drv)
);

// File: tb/edo_out_ctrl_bench.sv
`timescale 1ns/1ps
module edo_out_ctrl_bench;
  localparam int DW = 16;
  localparam int RW = 3;
  localparam int CW = 3;
  localparam int AW = 3;
  localparam int NC = 1 << (RW + CW);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ras_n, cas_n, we_n, oe_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  logic [DW-1:0] exp_mem [NC];
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 0;

  always #2.5 clk = ~clk;

  edo_out_ctrl #(.DW(DW), .ROW_W(RW), .COL_W(CW)) u_edo_out_ctrl (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [DW-1:0] pat(input int r, input int c);
    return DW'((r << 12) | (c << 6) | (r * 7 + c * 3)) ^ 16'h5A00;
  endfunction

  function automatic int idx(input int r, input int c);
    return (r << CW) | c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW:0] act, input logic [DW:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic chk_drv(input string req, input logic [DW-1:0] d);
    chk(dq_oe === 1'b1 && dq_out === d, req, {dq_oe, dq_out}, {1'b1, d});
  endtask

  task automatic chk_off(input string req);
    chk(dq_oe === 1'b0, req, {dq_oe, dq_out}, {1'b0, dq_out});
  endtask

  task automatic cyc(input logic r, input logic c, input logic w, input logic o,
                     input int a, input logic [DW-1:0] d);
    @(negedge clk);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = AW'(a); dq_in = d;
    @(posedge clk);
    #1;
  endtask

  task automatic read_chk(input int r, input int c, input string req);
    cyc(0, 1, 1, 0, r, 0);
    cyc(0, 0, 1, 0, c, 0);
    chk_drv(req, exp_mem[idx(r, c)]);
    cyc(0, 1, 1, 0, c, 0);
    cyc(1, 1, 1, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ras_n = 1; cas_n = 1; we_n = 1; oe_n = 0; addr = '0; dq_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) cyc(1, 1, 1, 0, 0, 0);
    chk_off("R1");

    // R6 fill every cell with early-write page cycles
    for (int r = 0; r < (1 << RW); r++) begin
      cyc(0, 1, 0, 0, r, 0);
      for (int c = 0; c < (1 << CW); c++) begin
        cyc(0, 0, 0, 0, c, pat(r, c));
        chk_off("R6");
        exp_mem[idx(r, c)] = pat(r, c);
        cyc(0, 1, 0, 0, c, 0);
      end
      cyc(1, 1, 1, 0, 0, 0);
    end

    // R2 R11 R3 page-mode read sweep
    for (int r = 0; r < (1 << RW); r++) begin
      cyc(0, 1, 1, 0, r, 0);
      for (int c = 0; c < (1 << CW); c++) begin
        cyc(0, 0, 1, 0, c, 0);
        chk_drv("R2/R11", pat(r, c));
        cyc(0, 1, 1, 0, c, 0);
        chk_drv("R3", pat(r, c));
      end
      cyc(1, 1, 1, 0, 0, 0);
      chk_off("R4");
    end

    // R4 row strobe rises first
    cyc(0, 1, 1, 0, 2, 0);
    cyc(0, 0, 1, 0, 5, 0);
    cyc(1, 0, 1, 0, 0, 0);
    chk_drv("R4", exp_mem[idx(2, 5)]);
    cyc(1, 1, 1, 0, 0, 0);
    chk_off("R4");

    // R5 output enable gating
    cyc(0, 1, 1, 0, 4, 0);
    cyc(0, 0, 1, 0, 1, 0);
    cyc(0, 0, 1, 1, 1, 0);
    chk(dq_oe === 1'b0 && dq_out === exp_mem[idx(4, 1)], "R5", {dq_oe, dq_out}, {1'b0, exp_mem[idx(4, 1)]});
    cyc(0, 0, 1, 0, 1, 0);
    chk_drv("R5", exp_mem[idx(4, 1)]);
    cyc(0, 1, 1, 0, 0, 0);
    cyc(1, 1, 1, 0, 0, 0);

    // R7 read-modify-write
    cyc(0, 1, 1, 0, 6, 0);
    cyc(0, 0, 1, 0, 3, 0);
    chk_drv("R7", exp_mem[idx(6, 3)]);
    cyc(0, 0, 0, 0, 7, 16'hBEEF);
    chk_off("R7");
    exp_mem[idx(6, 3)] = 16'hBEEF;
    cyc(0, 1, 1, 0, 0, 0);
    cyc(1, 1, 1, 0, 0, 0);
    // R7 late write with output disabled
    cyc(0, 1, 1, 1, 1, 0);
    cyc(0, 0, 1, 1, 2, 0);
    chk_off("R7");
    cyc(0, 0, 0, 1, 2, 16'h1234);
    chk_off("R7");
    exp_mem[idx(1, 2)] = 16'h1234;
    cyc(0, 1, 1, 0, 0, 0);
    cyc(1, 1, 1, 0, 0, 0);
    read_chk(6, 3, "R7");
    read_chk(1, 2, "R7");

    // R8 RAS-only refresh
    cyc(0, 1, 1, 0, 6, 0);
    cyc(0, 1, 1, 0, 6, 0);
    chk_off("R8");
    cyc(0, 1, 0, 0, 3, 16'hFFFF);
    chk_off("R8");
    cyc(1, 1, 1, 0, 0, 0);
    read_chk(6, 3, "R8");

    // R9 hidden refresh keeps the driven data
    cyc(0, 1, 1, 0, 5, 0);
    cyc(0, 0, 1, 0, 5, 0);
    cyc(1, 0, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    chk_drv("R9", exp_mem[idx(5, 5)]);
    cyc(0, 0, 0, 0, 0, 16'h0F0F);
    chk_drv("R9", exp_mem[idx(5, 5)]);
    cyc(1, 0, 1, 0, 0, 0);
    cyc(1, 1, 1, 0, 0, 0);
    chk_off("R9");
    // R9 standalone CAS-before-RAS
    cyc(1, 0, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    chk_off("R9");
    cyc(1, 1, 1, 0, 0, 0);

    // R10 CAS-only cycles
    cyc(1, 0, 0, 0, 3, 16'hDEAD);
    chk_off("R10");
    cyc(1, 1, 1, 0, 0, 0);
    cyc(1, 0, 1, 0, 3, 0);
    chk_off("R10");
    cyc(1, 1, 1, 0, 0, 0);

    // R8 R9 R10 final sweep: no cell changed by refresh or CAS-only cycles
    for (int r = 0; r < (1 << RW); r++)
      for (int c = 0; c < (1 << CW); c++)
        read_chk(r, c, "R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule